// File: doc/BRIEF.md
# Composite Sync and Blank Combiner with Equalization and Serration

This block merges separately generated horizontal and vertical timing into one composite sync line and one composite blank line. The blank output is the active-low AND of the horizontal and vertical blanks. For the sync output, the block can insert pulse trains around the vertical sync interval. While vertical sync is asserted, the plain sync is replaced by broad serration pulses. For a programmable number of sub-periods before and after that interval, it is replaced by narrow equalization pulses. Everywhere else the composite sync follows horizontal sync.

A sub-period is a whole line in single mode. It is half a line when interlace or double mode is selected, so the pulses then repeat at twice the line rate. The half-line length is the programmed line length divided by two. The line counter, the frame counter and register storage live outside the block, which only reads their values. Each output has its own polarity bit. Both outputs are registered, so they follow the inputs by one clock.

Top module: `csync_compositor`

## Requirements
- R1: `cblank` equals `(hb_n & vb_n) ^ blank_pol`, as sampled one clock earlier.
- R2: With `pulse_en` = 0, `csync` equals `(hs_n & vs_n) ^ sync_pol`, as sampled one clock earlier.
- R3: With `pulse_en` = 1, `vs_n` = 1 and the position outside the equalization window, `csync` equals `hs_n ^ sync_pol`, as sampled one clock earlier.
- R4: Inside the equalization window while `vs_n` = 1, the active-low sync is 0 exactly when `pulse_start <= local < eq_end`.
- R5: While `vs_n` = 0 with `pulse_en` = 1, the active-low sync is 0 exactly when `local >= serr_start` or `local < pulse_start`.
- R6: The sub-period is doubled when `mode_interlace | mode_double` = 1. In that case `half = line_len >> 1`, and for `h_cnt > half` the local count is `h_cnt - half` with sub index 1; otherwise the local count is `h_cnt` with sub index 0. In single mode the local count is `h_cnt` and the sub index is 0.
- R7: The position is `(v_cnt << d) + sub`, where d is 1 when doubled and 0 otherwise. The equalization window holds positions in `[(vs_first<<d) - eq_pre, vs_first<<d)` and in `[vs_last_next<<d, (vs_last_next<<d) + eq_post)`.
- R8: Setting `sync_pol` or `blank_pol` to 1 inverts only that output and leaves its timing unchanged.
- R9: During reset, `csync` = `~sync_pol` and `cblank` = `~blank_pol`, the inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cnt | input | HW | Horizontal count, 1 to line_len |
| v_cnt | input | VW | Line count within the frame, starting at 1 |
| hs_n | input | 1 | Horizontal sync, active low |
| hb_n | input | 1 | Horizontal blank, active low |
| vs_n | input | 1 | Vertical sync, active low |
| vb_n | input | 1 | Vertical blank, active low |
| line_len | input | HW | Clocks per line, even |
| pulse_start | input | HW | Local count where equalization starts and serration ends |
| eq_end | input | HW | Local count that ends an equalization pulse |
| serr_start | input | HW | Local count that starts a serration pulse |
| vs_first | input | VW | First line of vertical sync |
| vs_last_next | input | VW | Line after the last vertical sync line |
| eq_pre | input | EW | Equalization sub-periods before vertical sync |
| eq_post | input | EW | Equalization sub-periods after vertical sync |
| mode_interlace | input | 1 | Interlaced operation, which doubles the sub-period rate |
| mode_double | input | 1 | Double serration/equalization when not interlaced |
| pulse_en | input | 1 | Enables equalization and serration insertion |
| sync_pol | input | 1 | 1 gives active-high composite sync |
| blank_pol | input | 1 | 1 gives active-high composite blank |
| csync | output | 1 | Composite sync |
| cblank | output | 1 | Composite blank |

## Verification
A wrong half-line split moves the second pulse of each line to a new place. It also shifts every equalization and serration edge in that half by half a line, so the error shows within one line of entering the vertical interval. A position or window-bound error grows or shrinks the equalization group by whole sub-periods at its edges, one clock after the affected position. A polarity or combine error shows on the very next clock after reset.

// File: rtl/csync_pkg.sv
// Shared types for the composite sync combiner.
// Assumes: nothing beyond standard SystemVerilog.
package csync_pkg;
    // Which shaping rule drives composite sync at the current position.
    typedef enum logic [1:0] {
        SEL_RAW   = 2'd0,  // plain AND of horizontal and vertical sync
        SEL_HSYNC = 2'd1,  // horizontal sync only
        SEL_EQ    = 2'd2,  // equalization pulse
        SEL_SERR  = 2'd3   // serration pulse
    } sync_sel_t;
endpackage

// File: rtl/csync_subperiod.sv
// Splits the horizontal count into a sub-period index and a local count.
// In doubled mode a line holds two sub-periods of line_len/2 clocks each.
// Assumes: h_cnt runs 1..line_len and line_len is even.
module csync_subperiod #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_cnt,
    input  logic [HW-1:0] line_len,
    input  logic          dbl,
    output logic          sub,
    output logic [HW-1:0] local_cnt
);
    logic [HW-1:0] half;
    logic [HW-1:0] sub_len;

    // Derive the half-line boundary, then the sub index and local count.
    always_comb begin
        half      = line_len >> 1;
        sub       = dbl && (h_cnt > half);
        local_cnt = sub ? (h_cnt - half) : h_cnt;
        sub_len   = dbl ? half : line_len;
    end

    AST_LOCAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt >= 1 && h_cnt <= line_len) |-> (local_cnt >= 1 && local_cnt <= sub_len)); // R6
endmodule

// File: rtl/csync_window.sv
// Decides whether the current sub-period lies in the equalization window
// just before or just after the vertical sync lines.
// Assumes: vs_first <= vs_last_next, both counted in lines starting at 1.
module csync_window #(
    parameter int VW = 11,
    parameter int EW = 6
) (
    input  logic          dbl,
    input  logic          sub,
    input  logic [VW-1:0] v_cnt,
    input  logic [VW-1:0] vs_first,
    input  logic [VW-1:0] vs_last_next,
    input  logic [EW-1:0] eq_pre,
    input  logic [EW-1:0] eq_post,
    output logic          in_eq
);
    localparam int PW = VW + 2;

    logic [PW-1:0] pos;
    logic [PW-1:0] lo;
    logic [PW-1:0] hi;

    // Place the position and the sync bounds in sub-period units, then compare.
    always_comb begin
        pos   = (PW'(v_cnt) << dbl) + PW'(sub);
        lo    = PW'(vs_first) << dbl;
        hi    = PW'(vs_last_next) << dbl;
        in_eq = ((pos < lo) && ((pos + PW'(eq_pre)) >= lo))
             || ((pos >= hi) && (pos < (hi + PW'(eq_post))));
    end
endmodule

// File: rtl/csync_shaper.sv
// Produces active-low equalization and serration pulse shapes from the
// local count within a sub-period.
// Assumes: pulse_start <= eq_end, and serr_start lies within the sub-period.
module csync_shaper #(
    parameter int HW = 12
) (
    input  logic [HW-1:0] local_cnt,
    input  logic [HW-1:0] pulse_start,
    input  logic [HW-1:0] eq_end,
    input  logic [HW-1:0] serr_start,
    output logic          eq_n,
    output logic          serr_n
);
    // A narrow low pulse inside the sub-period; a broad low pulse that wraps its end.
    always_comb begin
        eq_n   = !((local_cnt >= pulse_start) && (local_cnt < eq_end));
        serr_n = !((local_cnt >= serr_start) || (local_cnt < pulse_start));
    end
endmodule

// File: rtl/csync_compositor.sv
// Composite sync and blank combiner. Blank is the AND of the active-low
// components. Sync follows horizontal sync but is replaced by serration
// during vertical sync and by equalization in a window around it.
// Outputs are registered with per-output polarity.
// Assumes: counters and registers are supplied from outside and stable per clock.
module csync_compositor
    import csync_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic          hs_n,
    input  logic          hb_n,
    input  logic          vs_n,
    input  logic          vb_n,
    input  logic [HW-1:0] line_len,
    input  logic [HW-1:0] pulse_start,
    input  logic [HW-1:0] eq_end,
    input  logic [HW-1:0] serr_start,
    input  logic [VW-1:0] vs_first,
    input  logic [VW-1:0] vs_last_next,
    input  logic [EW-1:0] eq_pre,
    input  logic [EW-1:0] eq_post,
    input  logic          mode_interlace,
    input  logic          mode_double,
    input  logic          pulse_en,
    input  logic          sync_pol,
    input  logic          blank_pol,
    output logic          csync,
    output logic          cblank
);
    logic          dbl;
    logic          sub;
    logic [HW-1:0] local_cnt;
    logic          in_eq;
    logic          eq_n;
    logic          serr_n;
    sync_sel_t     sel;
    logic          sync_low_n;

    assign dbl = mode_interlace | mode_double;

    csync_subperiod #(.HW(HW)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_cnt     (h_cnt),
        .line_len  (line_len),
        .dbl       (dbl),
        .sub       (sub),
        .local_cnt (local_cnt)
    );

    csync_window #(.VW(VW), .EW(EW)) u_win (
        .dbl          (dbl),
        .sub          (sub),
        .v_cnt        (v_cnt),
        .vs_first     (vs_first),
        .vs_last_next (vs_last_next),
        .eq_pre       (eq_pre),
        .eq_post      (eq_post),
        .in_eq        (in_eq)
    );

    csync_shaper #(.HW(HW)) u_shape (
        .local_cnt   (local_cnt),
        .pulse_start (pulse_start),
        .eq_end      (eq_end),
        .serr_start  (serr_start),
        .eq_n        (eq_n),
        .serr_n      (serr_n)
    );

    // Choose the shaping rule for this clock.
    always_comb begin
        if (!pulse_en)  sel = SEL_RAW;
        else if (!vs_n) sel = SEL_SERR;
        else if (in_eq) sel = SEL_EQ;
        else            sel = SEL_HSYNC;
    end

    // Apply the chosen rule to form the active-low composite sync.
    always_comb begin
        unique case (sel)
            SEL_RAW:   sync_low_n = hs_n & vs_n;
            SEL_HSYNC: sync_low_n = hs_n;
            SEL_EQ:    sync_low_n = eq_n;
            SEL_SERR:  sync_low_n = serr_n;
            default:   sync_low_n = 1'b1;
        endcase
    end

    // Register both outputs with polarity; reset drives the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync  <= ~sync_pol;
            cblank <= ~blank_pol;
        end else begin
            csync  <= sync_low_n ^ sync_pol;
            cblank <= (hb_n & vb_n) ^ blank_pol;
        end
    end

    AST_BLANK_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cblank == ($past(hb_n & vb_n) ^ $past(blank_pol)))); // R1
    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pulse_en)) |-> (csync == ($past(hs_n & vs_n) ^ $past(sync_pol)))); // R2
    AST_EQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pulse_en && vs_n && in_eq && (local_cnt < pulse_start)))
        |-> (csync == ~$past(sync_pol))); // R4
    AST_SERR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pulse_en && !vs_n && (local_cnt < pulse_start)))
        |-> (csync == $past(sync_pol))); // R5
endmodule

// File: tb/sim_csync_compositor.sv
// Scoreboard bench: the driver pushes an expected output pair for every
// driven clock, and the monitor pops and compares just after the edge.
module sim_csync_compositor;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int EW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HW-1:0] h_cnt = 1, line_len = 100, pulse_start = 5, eq_end = 9, serr_start = 48;
    logic [VW-1:0] v_cnt = 1, vs_first = 4, vs_last_next = 7;
    logic [EW-1:0] eq_pre = 3, eq_post = 3;
    logic hs_n = 1, hb_n = 1, vs_n = 1, vb_n = 1;
    logic mode_interlace = 0, mode_double = 1, pulse_en = 1, sync_pol = 0, blank_pol = 0;
    logic csync, cblank;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct { logic s; logic b; string tag; } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    csync_compositor #(.HW(HW), .VW(VW), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .hs_n(hs_n), .hb_n(hb_n), .vs_n(vs_n), .vb_n(vb_n),
        .line_len(line_len), .pulse_start(pulse_start), .eq_end(eq_end),
        .serr_start(serr_start), .vs_first(vs_first), .vs_last_next(vs_last_next),
        .eq_pre(eq_pre), .eq_post(eq_post), .mode_interlace(mode_interlace),
        .mode_double(mode_double), .pulse_en(pulse_en), .sync_pol(sync_pol),
        .blank_pol(blank_pol), .csync(csync), .cblank(cblank));

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one position of a test frame and queue its expected outputs.
    task automatic drive(input int h, input int v);
        exp_t e;
        int d, half, sb, loc, pos, lo, hi;
        bit in_eq;
        logic low;
        @(negedge clk);
        h_cnt = HW'(h);
        v_cnt = VW'(v);
        hs_n  = !(h >= 5 && h < 13);
        hb_n  = !(h < 20);
        vs_n  = !(v >= int'(vs_first) && v < int'(vs_last_next));
        vb_n  = !(v < 3);
        d     = (mode_interlace || mode_double) ? 1 : 0;
        half  = int'(line_len) / 2;
        sb    = (d == 1 && h > half) ? 1 : 0;            // R6
        loc   = sb ? h - half : h;
        pos   = v * (1 << d) + sb;                        // R7
        lo    = int'(vs_first) * (1 << d);
        hi    = int'(vs_last_next) * (1 << d);
        in_eq = (pos < lo && pos >= lo - int'(eq_pre)) || (pos >= hi && pos < hi + int'(eq_post));
        if (!pulse_en) begin
            low = hs_n & vs_n; e.tag = "R2";
        end else if (!vs_n) begin
            low = !(loc >= int'(serr_start) || loc < int'(pulse_start)); e.tag = "R5";
        end else if (in_eq) begin
            low = !(loc >= int'(pulse_start) && loc < int'(eq_end)); e.tag = "R4 R7";
        end else begin
            low = hs_n; e.tag = "R3";
        end
        if (sb == 1) e.tag = {e.tag, " R6"};
        if (sync_pol || blank_pol) e.tag = {e.tag, " R8"};
        e.s = low ^ sync_pol;
        e.b = (hb_n & vb_n) ^ blank_pol;
        q.push_back(e);
    endtask

    task automatic frame();
        for (int v = 1; v <= 11; v++)
            for (int h = 1; h <= int'(line_len); h++)
                drive(h, v);
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " sync"}, csync, e.s);
            check("R1 blank", cblank, e.b);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset sync", csync, 1'b1);
        check("R9 reset blank", cblank, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        // Double mode, half-line pulses.
        frame();
        // Single mode: whole-line sub-period, serration near line end.
        @(negedge clk); mode_double = 0; serr_start = 92;
        frame();
        // Interlace also doubles.
        @(negedge clk); mode_interlace = 1; serr_start = 46; eq_pre = 2; eq_post = 5;
        frame();
        // Pulses disabled: plain AND.
        @(negedge clk); pulse_en = 0;
        frame();
        // Inverted polarity with pulses.
        @(negedge clk); pulse_en = 1; sync_pol = 1; blank_pol = 1;
        frame();
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule